// File: doc/BRIEF.md
# Serial Byte Receiver with Overrun Protection

This block receives asynchronous serial frames on a single idle-high line and turns each one into a byte. The line is timed by a sixteen-times oversampling tick. Each finished byte goes into a receive holding register, and a ready flag reports that a byte is waiting. Software, or any other consumer, takes the byte by pulsing a read strobe, and that strobe also drops the ready flag.

A byte can finish before the previous one has been taken. In that case the older byte stays in the holding register and the new byte is discarded. An overrun flag is raised and stays up until it is cleared explicitly through a write-one-to-clear register, and every byte that completes while the flag is up is dropped. One interrupt line combines the ready flag and the overrun flag under two enable inputs.

Top module: `uart_ovr_rx`

## Requirements
- R1: After a synchronous reset, rdy, ovr and irq are all 0.
- R2: A frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit. Each bit lasts 16 baud ticks. When the frame completes with rdy and ovr both 0, the byte appears on rd_data and rdy becomes 1.
- R3: Each bit is sampled once, 8 ticks into its period. A low level seen on a tick while idle begins a frame. If the line is high again at the start bit's midpoint, the receiver goes back to idle and produces no byte.
- R4: A cycle with rd_en high clears rdy. rd_data keeps its value.
- R5: When a byte completes while rdy is 1, ovr becomes 1 and rd_data keeps the earlier byte.
- R6: While ovr is 1, every completed byte is discarded, even when rdy is 0. rd_data and rdy are left unchanged.
- R7: ovr is cleared only by a cycle with clr_we high and bit 3 of clr_wdata set to 1. Other bits of clr_wdata have no effect.
- R8: irq is high when (rx_ie and (rdy or ovr)) or (err_ie and ovr).
- R9: A read in the same cycle that a byte completes, while rdy is 1, gives rdy 0 and ovr 1. The new byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rd_en | input | 1 | Read strobe for the holding register |
| rd_data | output | 8 | Holding register contents |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 8 | Clear register data; bit 3 clears overrun |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rdy | output | 1 | Data-ready flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
With the tick present every cycle, a frame whose start edge is driven just before clock edge E0 completes at E154, after the two-stage synchronizer and the 16-tick bit timing. Its flags and data change at E155, and the bench samples them only after the whole 160-cycle frame has been driven. Reads and clears take effect at the next edge, so the bench checks them one negative edge later. irq follows the flags and enables within the same cycle and is checked 1 ns after the enables change. For the same-cycle collision, the read strobe is placed at the 155th negative edge after the start bit so that it meets the completion edge exactly.

// File: rtl/uart_ovr_pkg.sv
package uart_ovr_pkg;
    localparam int BYTE_W      = 8;
    localparam int OSR         = 16;
    localparam int CNT_W       = $clog2(OSR);
    localparam int BIT_W       = $clog2(BYTE_W);
    localparam int CLR_W       = 8;
    localparam int OVR_CLR_BIT = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic logic mid_reached(input logic [CNT_W-1:0] c);
        return c == CNT_W'(OSR / 2 - 1);
    endfunction

    function automatic logic period_done(input logic [CNT_W-1:0] c);
        return c == CNT_W'(OSR - 1);
    endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_ovr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    output rx_byte_t byte_out
);
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            byte_out <= '0;
        end else begin
            byte_out.valid <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (mid_reached(cnt)) begin
                            cnt   <= '0;
                            bidx  <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (period_done(cnt)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[BYTE_W-1:1]};
                            if (bidx == BIT_W'(BYTE_W - 1)) state <= RX_STOP;
                            else                            bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (period_done(cnt)) begin
                            cnt            <= '0;
                            state          <= RX_IDLE;
                            byte_out.valid <= 1'b1;
                            byte_out.data  <= shreg;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R2
    byte_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        byte_out.valid |-> $past(state == RX_STOP));

    // R3
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && mid_reached(cnt) && line) |=> state == RX_IDLE);
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import uart_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_byte_t          byte_in,
    input  logic              rd_en,
    input  logic              clr_we,
    input  logic [CLR_W-1:0]  clr_wdata,
    output logic [BYTE_W-1:0] data_q,
    output logic              rdy_q,
    output logic              ovr_q
);
    logic clr_hit;
    logic accept;
    logic lose;

    assign clr_hit = clr_we && clr_wdata[OVR_CLR_BIT];
    assign accept  = byte_in.valid && !rdy_q && !ovr_q;
    assign lose    = byte_in.valid && rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept) data_q <= byte_in.data;

            if (accept)     rdy_q <= 1'b1;
            else if (rd_en) rdy_q <= 1'b0;

            if (lose)         ovr_q <= 1'b1;
            else if (clr_hit) ovr_q <= 1'b0;
        end
    end

    // R4
    held_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_q |=> $stable(data_q));

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_in.valid && rdy_q) |=> ovr_q);

    // R6
    discard_in_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_in.valid && ovr_q) |=> $stable(data_q));

    // R7
    ovr_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovr_q) |-> $past(clr_we && clr_wdata[OVR_CLR_BIT]));

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_in.valid && rdy_q && rd_en) |=> (!rdy_q && ovr_q));
endmodule

// File: rtl/uart_ovr_rx.sv
module uart_ovr_rx
    import uart_ovr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              clr_we,
    input  logic [CLR_W-1:0]  clr_wdata,
    input  logic              rx_ie,
    input  logic              err_ie,
    output logic              rdy,
    output logic              ovr,
    output logic              irq
);
    logic     line_s;
    rx_byte_t fr_byte;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rx_line),
        .dout(line_s)
    );

    rx_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .line    (line_s),
        .byte_out(fr_byte)
    );

    rx_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .byte_in  (fr_byte),
        .rd_en    (rd_en),
        .clr_we   (clr_we),
        .clr_wdata(clr_wdata),
        .data_q   (rd_data),
        .rdy_q    (rdy),
        .ovr_q    (ovr)
    );

    assign irq = (rx_ie && (rdy || ovr)) || (err_ie && ovr);

    // R8
    err_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (err_ie && ovr) |-> irq);

    // R8
    quiet_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!rdy && !ovr) |-> !irq);
endmodule

// File: tb/tb_uart_ovr_rx.sv
`timescale 1ns/1ps
module tb_uart_ovr_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       clr_we = 1'b0;
    logic [7:0] clr_wdata = '0;
    logic       rx_ie = 1'b0;
    logic       err_ie = 1'b0;
    logic       rdy, ovr, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_ovr_rx dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .baud_tick(baud_tick),
        .rd_en(rd_en), .rd_data(rd_data), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .rx_ie(rx_ie), .err_ie(err_ie), .rdy(rdy), .ovr(ovr), .irq(irq)
    );

    // each entry: {byte sent, byte expected in holding register}
    localparam logic [15:0] VEC [6] = '{
        16'hA5A5, 16'h0000, 16'hFFFF, 16'h3C3C, 16'h8181, 16'h6E6E
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (16) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic read_pulse();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear_wr(input logic [7:0] m);
        clr_we    = 1'b1;
        clr_wdata = m;
        @(negedge clk);
        clr_we    = 1'b0;
        clr_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        rx_ie = 1'b1; err_ie = 1'b1;
        #1;
        chk("R1 rdy", rdy, 0);
        chk("R1 ovr", ovr, 0);
        chk("R1 irq", irq, 0);
        @(negedge clk);
        rx_ie = 1'b0; err_ie = 1'b0;

        foreach (VEC[k]) begin
            send_byte(VEC[k][15:8]);
            chk("R2 rdy set", rdy, 1);
            chk("R2 data", rd_data, VEC[k][7:0]);
            chk("R5 no overrun", ovr, 0);
            read_pulse();
            chk("R4 rdy cleared", rdy, 0);
            chk("R4 data kept", rd_data, VEC[k][7:0]);
            repeat (3) @(negedge clk);
        end

        // R8 receive interrupt
        send_byte(8'h5A);
        rx_ie = 1'b1; #1;
        chk("R8 irq rx_ie rdy", irq, 1);
        @(negedge clk); rx_ie = 1'b0; #1;
        chk("R8 irq disabled", irq, 0);
        @(negedge clk);
        read_pulse();

        // R5 overrun keeps older byte
        send_byte(8'h12);
        send_byte(8'h34);
        chk("R5 ovr set", ovr, 1);
        chk("R5 data kept", rd_data, 8'h12);
        chk("R5 rdy still", rdy, 1);
        err_ie = 1'b1; #1;
        chk("R8 irq err_ie", irq, 1);
        @(negedge clk); err_ie = 1'b0; #1;
        chk("R8 irq off", irq, 0);
        @(negedge clk);
        read_pulse();
        chk("R4 rdy cleared in ovr", rdy, 0);
        chk("R7 ovr survives read", ovr, 1);

        // R6 bytes dropped while overrun
        send_byte(8'h56);
        chk("R6 rdy stays 0", rdy, 0);
        chk("R6 data unchanged", rd_data, 8'h12);

        // R7 clear needs bit 3
        clear_wr(8'hF7);
        chk("R7 other bits no effect", ovr, 1);
        clear_wr(8'h08);
        chk("R7 cleared", ovr, 0);
        send_byte(8'h77);
        chk("R2 after clear rdy", rdy, 1);
        chk("R2 after clear data", rd_data, 8'h77);

        // R9 read in the completion cycle
        fork
            send_byte(8'h99);
            begin
                repeat (155) @(negedge clk);
                rd_en = 1'b1;
                @(negedge clk);
                rd_en = 1'b0;
            end
        join
        chk("R9 rdy", rdy, 0);
        chk("R9 ovr", ovr, 1);
        chk("R9 data", rd_data, 8'h77);
        clear_wr(8'h08);

        // R3 false start
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3 false start no byte", rdy, 0);
        send_byte(8'hC3);
        chk("R3 recovered data", rd_data, 8'hC3);
        chk("R3 recovered rdy", rdy, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule